// File: doc/BRIEF.md
# Chained Descriptor Loader for a DMA Channel

This block feeds a single DMA channel with a series of transfer setups that sit in memory as a ring of descriptors. Software writes the address of the first descriptor into the head pointer and raises the trigger. The loader then reads the descriptor one word at a time over a request/valid memory port and places the words in the channel's configuration outputs. It then pulses the channel start and waits for the channel to report completion.

Each descriptor occupies five consecutive 32-bit words, at byte offsets +0, +4, +8, +12 and +16. The words are, in that order, source address, destination address, length, control and the link to the next descriptor. When a transfer completes, the loader follows the link to the next descriptor. The ring closes because the final descriptor links back to the first. The loader detects this when a fetched link equals the head pointer: it pulses list-done once and goes idle instead of running the ring again. An error response from memory stops the chain and raises a sticky error flag. A new trigger clears that flag.

Top module: `dlist_loader`

## Requirements
- R1: After reset, busy, rd_req, ch_start, list_done and err are 0, and head_addr is 0.
- R2: A write of ptr_wdata with ptr_we while the loader is idle appears on head_addr one cycle later.
- R3: A head pointer write made while busy is 1 is ignored, and head_addr keeps its value.
- R4: After a trigger, rd_req rises in the next cycle. The five descriptor words are read at addresses base+0, +4, +8, +12 and +16, in that order. rd_req and rd_addr hold steady until rd_valid accepts each beat.
- R5: Words 0 to 3 drive ch_src, ch_dst, ch_len and ch_ctrl. ch_start is a one-cycle pulse in the cycle after the fifth word is accepted. The configuration stays stable while no beat is being accepted.
- R6: When ch_done arrives and the fetched link differs from head_addr, rd_req rises in the next cycle with rd_addr equal to the link.
- R7: When ch_done arrives and the fetched link equals head_addr, list_done pulses for one cycle in the next cycle and busy falls with it. No further reads or starts follow.
- R8: A beat accepted with rd_err set ends the chain in the next cycle: err becomes 1 and busy 0, with no start and no list_done. err holds until the next trigger, which clears it.
- R9: A trigger while busy is ignored, and the chain in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptr_we | input | 1 | Head pointer write strobe |
| ptr_wdata | input | 32 | Head pointer write value (byte address) |
| trig | input | 1 | Start the chain from the head pointer |
| head_addr | output | 32 | Current head pointer |
| rd_req | output | 1 | Memory read request, held until accepted |
| rd_addr | output | 32 | Memory read byte address |
| rd_valid | input | 1 | Read response valid, which accepts the request |
| rd_data | input | 32 | Read response data |
| rd_err | input | 1 | Read response error, qualified by rd_valid |
| ch_start | output | 1 | One-cycle channel start pulse |
| ch_src | output | 32 | Channel source address |
| ch_dst | output | 32 | Channel destination address |
| ch_len | output | 32 | Channel transfer length |
| ch_ctrl | output | 32 | Channel control word |
| ch_done | input | 1 | Channel transfer complete |
| busy | output | 1 | Loader is fetching or running a transfer |
| list_done | output | 1 | One-cycle pulse when the ring has closed |
| err | output | 1 | Sticky read error flag |

## Verification
Every result of the loader is due exactly one clock after the input that causes it. This holds for a head write, a trigger (rd_req), the fifth accepted beat (ch_start), ch_done (next rd_req, or list_done with busy low) and an error beat (err with busy low). The bench drives every input at the falling edge. It checks the matching output at the next falling edge, which is the first one after the rising edge that consumed the input. The memory responder checks each requested address against the address the bench computes from its own descriptor layout, so that the order of reads and the walk along the links are checked beat by beat.

// File: rtl/dlist_pkg.sv
package dlist_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_RUN   = 2'd2
  } ld_state_t;

  localparam int unsigned DESC_WORDS = 5;
  localparam int unsigned CFG_WORDS  = DESC_WORDS - 1;
  localparam int unsigned IDX_W      = $clog2(DESC_WORDS);
endpackage

// File: rtl/dlist_cfg_bank.sv
module dlist_cfg_bank #(
  parameter int unsigned DW    = 32,
  parameter int unsigned NCFG  = 4,
  parameter int unsigned IDX_W = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [IDX_W-1:0]          widx,
  input  logic [DW-1:0]             wdata,
  output logic [NCFG-1:0][DW-1:0]   cfg
);
  for (genvar g = 0; g < NCFG; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg[g] <= '0;
      end else if (we && (widx == IDX_W'(g))) begin
        cfg[g] <= wdata;
      end
    end
  end
endmodule

// File: rtl/dlist_seq.sv
module dlist_seq
  import dlist_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned DW     = 32,
  parameter int unsigned NWORDS = 5,
  parameter int unsigned IDX_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ptr_we,
  input  logic [AW-1:0]    ptr_wdata,
  input  logic             trig,
  output logic [AW-1:0]    head_addr,
  output logic             rd_req,
  output logic [AW-1:0]    rd_addr,
  input  logic             rd_valid,
  input  logic [DW-1:0]    rd_data,
  input  logic             rd_err,
  output logic             ch_start,
  input  logic             ch_done,
  output logic             busy,
  output logic             list_done,
  output logic             err,
  output logic             cfg_we,
  output logic [IDX_W-1:0] cfg_idx
);
  localparam logic [AW-1:0]    STEP     = AW'(DW / 8);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NWORDS - 1);

  ld_state_t        st_q;
  logic [IDX_W-1:0] widx_q;
  logic [AW-1:0]    link_q;
  logic             beat;
  logic             last_beat;

  assign beat      = rd_req && rd_valid;
  assign last_beat = (widx_q == LAST_IDX);
  assign cfg_we    = beat && !rd_err && !last_beat;
  assign cfg_idx   = widx_q;
  assign busy      = (st_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      widx_q    <= '0;
      link_q    <= '0;
      head_addr <= '0;
      rd_req    <= 1'b0;
      rd_addr   <= '0;
      ch_start  <= 1'b0;
      list_done <= 1'b0;
      err       <= 1'b0;
    end else begin
      ch_start  <= 1'b0;
      list_done <= 1'b0;
      if (st_q == ST_IDLE && ptr_we) begin
        head_addr <= ptr_wdata;
      end
      case (st_q)
        ST_IDLE: begin
          if (trig) begin
            st_q    <= ST_FETCH;
            rd_req  <= 1'b1;
            rd_addr <= head_addr;
            widx_q  <= '0;
            err     <= 1'b0;
          end
        end
        ST_FETCH: begin
          if (beat) begin
            if (rd_err) begin
              err    <= 1'b1;
              rd_req <= 1'b0;
              st_q   <= ST_IDLE;
            end else begin
              rd_addr <= rd_addr + STEP;
              widx_q  <= widx_q + 1'b1;
              if (last_beat) begin
                link_q   <= rd_data[AW-1:0];
                rd_req   <= 1'b0;
                ch_start <= 1'b1;
                st_q     <= ST_RUN;
              end
            end
          end
        end
        ST_RUN: begin
          if (ch_done) begin
            if (link_q == head_addr) begin
              list_done <= 1'b1;
              st_q      <= ST_IDLE;
            end else begin
              st_q    <= ST_FETCH;
              rd_req  <= 1'b1;
              rd_addr <= link_q;
              widx_q  <= '0;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

  // R5
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ch_start |=> !ch_start);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    list_done |-> (!busy && !rd_req && !ch_start));

  // R3
  head_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && ptr_we) |=> $stable(head_addr));

  // R8
  err_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && rd_valid && rd_err) |=> (err && !busy && !ch_start && !list_done));
endmodule

// File: rtl/dlist_loader.sv
module dlist_loader
  import dlist_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ptr_we,
  input  logic [AW-1:0] ptr_wdata,
  input  logic          trig,
  output logic [AW-1:0] head_addr,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data,
  input  logic          rd_err,
  output logic          ch_start,
  output logic [DW-1:0] ch_src,
  output logic [DW-1:0] ch_dst,
  output logic [DW-1:0] ch_len,
  output logic [DW-1:0] ch_ctrl,
  input  logic          ch_done,
  output logic          busy,
  output logic          list_done,
  output logic          err
);
  logic                         cfg_we;
  logic [IDX_W-1:0]             cfg_idx;
  logic [CFG_WORDS-1:0][DW-1:0] cfg;

  dlist_seq #(
    .AW(AW), .DW(DW), .NWORDS(DESC_WORDS), .IDX_W(IDX_W)
  ) u_seq (
    .clk(clk), .rst(rst),
    .ptr_we(ptr_we), .ptr_wdata(ptr_wdata), .trig(trig),
    .head_addr(head_addr),
    .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err),
    .ch_start(ch_start), .ch_done(ch_done),
    .busy(busy), .list_done(list_done), .err(err),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx)
  );

  dlist_cfg_bank #(
    .DW(DW), .NCFG(CFG_WORDS), .IDX_W(IDX_W)
  ) u_bank (
    .clk(clk), .rst(rst),
    .we(cfg_we), .widx(cfg_idx), .wdata(rd_data),
    .cfg(cfg)
  );

  assign ch_src  = cfg[0];
  assign ch_dst  = cfg[1];
  assign ch_len  = cfg[2];
  assign ch_ctrl = cfg[3];

  // R5
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_req && rd_valid) |=> $stable(cfg));
endmodule

// File: tb/dlist_loader_bench.sv
module dlist_loader_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ptr_we = 1'b0;
  logic [31:0] ptr_wdata = '0;
  logic        trig = 1'b0;
  logic [31:0] head_addr;
  logic        rd_req;
  logic [31:0] rd_addr;
  logic        rd_valid = 1'b0;
  logic [31:0] rd_data = '0;
  logic        rd_err = 1'b0;
  logic        ch_start;
  logic [31:0] ch_src, ch_dst, ch_len, ch_ctrl;
  logic        ch_done = 1'b0;
  logic        busy, list_done, err;

  always #5 clk = ~clk;

  dlist_loader u_dlist_loader (
    .clk(clk), .rst(rst), .ptr_we(ptr_we), .ptr_wdata(ptr_wdata), .trig(trig),
    .head_addr(head_addr), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err),
    .ch_start(ch_start), .ch_src(ch_src), .ch_dst(ch_dst), .ch_len(ch_len),
    .ch_ctrl(ch_ctrl), .ch_done(ch_done), .busy(busy),
    .list_done(list_done), .err(err)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  logic [31:0] mem [0:511];
  logic [31:0] exp_base [0:7];
  logic [31:0] exp_cfg  [0:7][0:3];
  int          beat_idx = 0;
  int          st_cnt = 0;
  int          ld_cnt = 0;
  bit          err_en = 1'b0;
  logic [31:0] err_addr = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd_addr(input int b);
    return exp_base[b / 5] + 32'(4 * (b % 5));
  endfunction

  // memory responder: random wait states, address checked against layout
  always @(negedge clk) begin
    rd_valid <= 1'b0;
    rd_err   <= 1'b0;
    if (!rst && rd_req && ($urandom % 3 != 0)) begin
      if (rd_addr !== exp_rd_addr(beat_idx)) begin
        n_fail++;
        $display("FAIL R4 actual=%h expected=%h", rd_addr, exp_rd_addr(beat_idx));
      end
      n_tests++;
      beat_idx++;
      rd_valid <= 1'b1;
      rd_data  <= mem[rd_addr[10:2]];
      rd_err   <= err_en && (rd_addr == err_addr);
    end
  end

  always @(negedge clk) begin
    if (!rst && ch_start)  st_cnt++;
    if (!rst && list_done) ld_cnt++;
  end

  task automatic build_chain(input int n);
    int perm [0:7];
    for (int i = 0; i < 8; i++) perm[i] = i;
    for (int i = 7; i > 0; i--) begin
      int j;
      int t;
      j = int'($urandom % (i + 1));
      t = perm[i]; perm[i] = perm[j]; perm[j] = t;
    end
    for (int i = 0; i < n; i++) exp_base[i] = 32'(64 + perm[i] * 32);
    for (int i = 0; i < n; i++) begin
      for (int w = 0; w < 4; w++) begin
        exp_cfg[i][w] = $urandom;
        mem[(exp_base[i] >> 2) + 32'(w)] = exp_cfg[i][w];
      end
      mem[(exp_base[i] >> 2) + 32'd4] = (i == n - 1) ? exp_base[0] : exp_base[i + 1];
    end
  endtask

  task automatic write_head(input logic [31:0] a);
    @(negedge clk); ptr_we = 1'b1; ptr_wdata = a;
    @(negedge clk); ptr_we = 1'b0;
    chk(head_addr == a, "R2 head write", head_addr, a);
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    chk(busy && rd_req, "R4 rd_req after trig", {30'd0, busy, rd_req}, 32'd3);
    chk(err == 1'b0, "R8 err cleared by trig", {31'd0, err}, 32'd0);
  endtask

  task automatic wait_start(output bit ok);
    ok = 1'b0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (ch_start) begin ok = 1'b1; break; end
    end
  endtask

  task automatic run_desc(input int i, input int n, input bit poke);
    bit ok;
    wait_start(ok);
    chk(ok, "R5 ch_start seen", {31'd0, ok}, 32'd1);
    chk(ch_src  == exp_cfg[i][0], "R5 src",  ch_src,  exp_cfg[i][0]);
    chk(ch_dst  == exp_cfg[i][1], "R5 dst",  ch_dst,  exp_cfg[i][1]);
    chk(ch_len  == exp_cfg[i][2], "R5 len",  ch_len,  exp_cfg[i][2]);
    chk(ch_ctrl == exp_cfg[i][3], "R5 ctrl", ch_ctrl, exp_cfg[i][3]);
    @(negedge clk);
    chk(!ch_start, "R5 start one cycle", {31'd0, ch_start}, 32'd0);
    if (poke) begin
      ptr_we = 1'b1; ptr_wdata = 32'hDEAD_0000; trig = 1'b1;
      @(negedge clk);
      ptr_we = 1'b0; trig = 1'b0;
      chk(head_addr == exp_base[0], "R3 write while busy", head_addr, exp_base[0]);
      chk(busy && !rd_req, "R9 trig while busy", {30'd0, busy, rd_req}, 32'd2);
    end
    repeat (int'($urandom % 5)) @(negedge clk);
    chk(ch_src == exp_cfg[i][0], "R5 cfg stable", ch_src, exp_cfg[i][0]);
    ch_done = 1'b1;
    @(negedge clk);
    ch_done = 1'b0;
    if (i < n - 1) begin
      chk(rd_req && busy && !list_done, "R6 follow link", {29'd0, rd_req, busy, list_done}, 32'd6);
      chk(rd_addr == exp_base[i + 1], "R6 link address", rd_addr, exp_base[i + 1]);
    end else begin
      chk(list_done && !busy && !rd_req, "R7 ring closed", {29'd0, list_done, busy, rd_req}, 32'd4);
      @(negedge clk);
      chk(!list_done, "R7 list_done one cycle", {31'd0, list_done}, 32'd0);
    end
  endtask

  task automatic run_chain(input int n, input bit poke);
    int s0;
    int l0;
    build_chain(n);
    beat_idx = 0;
    s0 = st_cnt; l0 = ld_cnt;
    write_head(exp_base[0]);
    pulse_trig();
    for (int i = 0; i < n; i++) run_desc(i, n, poke && (i == 0));
    repeat (20) @(negedge clk);
    chk(!busy && !rd_req, "R7 stays idle", {30'd0, busy, rd_req}, 32'd0);
    chk(st_cnt - s0 == n, "R7 start count", 32'(st_cnt - s0), 32'(n));
    chk(ld_cnt - l0 == 1, "R7 list_done count", 32'(ld_cnt - l0), 32'd1);
    chk(beat_idx == 5 * n, "R4 beat count", 32'(beat_idx), 32'(5 * n));
  endtask

  task automatic run_error();
    int s0;
    int l0;
    bit ok;
    build_chain(3);
    beat_idx = 0;
    s0 = st_cnt; l0 = ld_cnt;
    err_en = 1'b1; err_addr = exp_base[1] + 32'd8;
    write_head(exp_base[0]);
    pulse_trig();
    wait_start(ok);
    chk(ok, "R8 first desc runs", {31'd0, ok}, 32'd1);
    @(negedge clk); ch_done = 1'b1;
    @(negedge clk); ch_done = 1'b0;
    ok = 1'b0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (!busy) begin ok = 1'b1; break; end
    end
    chk(ok && err, "R8 abort sets err", {30'd0, ok, err}, 32'd3);
    repeat (10) @(negedge clk);
    chk(err && !busy, "R8 err sticky", {30'd0, err, busy}, 32'd2);
    chk(st_cnt - s0 == 1, "R8 no further start", 32'(st_cnt - s0), 32'd1);
    chk(ld_cnt == l0, "R8 no list_done", 32'(ld_cnt - l0), 32'd0);
    chk(beat_idx == 8, "R8 beats until error", 32'(beat_idx), 32'd8);
    err_en = 1'b0;
    beat_idx = 0;
    pulse_trig();
    for (int i = 0; i < 3; i++) run_desc(i, 3, 1'b0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 512; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(!busy && !rd_req && !ch_start && !list_done && !err,
        "R1 reset outputs", {27'd0, busy, rd_req, ch_start, list_done, err}, 32'd0);
    chk(head_addr == 32'd0, "R1 reset head", head_addr, 32'd0);
    run_chain(1, 1'b0);
    run_chain(3, 1'b1);
    for (int r = 0; r < 4; r++) run_chain(1 + int'($urandom % 8), 1'b0);
    run_chain(8, 1'b1);
    run_error();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule